// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer a small processor core uses to service one maskable interrupt request. The core signals the end of each instruction with a strobe. The sequencer samples the level-sensitive request line only at that strobe, and only while the enable bit in the processor status word is set. When it accepts a request, it pulses an acknowledge to the device. It then pushes the interrupted program counter and the status word onto a descending stack in memory. Finally it loads the program counter with a fixed handler address, and loads the status word with the enable bit cleared so that a second request waits.

A return strobe from the core reverses the sequence. The status word is popped first and the program counter second, and each is loaded back into the core as its read data arrives. Because the enable bit comes back with the popped status word, interrupts are re-enabled on return without a separate step. A busy output tells the core to stall fetching while either sequence runs.

States: `ST_IDLE` waits. `ST_ACK` pulses the acknowledge. `ST_PUSH_PC` and `ST_PUSH_PSW` write the stack. `ST_VECTOR` loads the handler entry. `ST_POP_PSW` and `ST_POP_PC` read the stack. `ST_RESUME` loads the restored PC. Transitions:
- accept: `ST_IDLE` to `ST_ACK`, taken on boundary, request and enable all true.
- return: `ST_IDLE` to `ST_POP_PSW`, taken on the return strobe.
- The remaining states each advance unconditionally to the next one in the sequence.
- `ST_VECTOR` and `ST_RESUME` go back to `ST_IDLE`.

Top module: `irq_seq`

## Requirements
- R1: After reset, irq_ack, busy, mem_we, mem_re, pc_load and psw_load are all 0.
- R2: A request is only taken in a cycle where insn_end is 1. A request that is raised and dropped between boundaries produces no acknowledge and no stack write.
- R3: When insn_end, irq_req and PSW bit 15 (the interrupt enable) are all 1 at a clock edge, irq_ack is 1 for exactly the one following cycle.
- R4: The stack pointer resets to 0x0100 and is decremented before each write. In the cycle after the acknowledge, the PC sampled at the accepting edge is written at SP-1. In the next cycle, the PSW sampled at that edge is written at SP-2. mem_we and mem_re are never both 1.
- R5: In the cycle after the PSW push, pc_load and psw_load are both 1. pc_out is 0x0040 and psw_out is the saved PSW with bit 15 cleared.
- R6: busy is 1 from the acknowledge cycle through the handler-load cycle, and 0 in the cycle after that.
- R7: While PSW bit 15 is 0, a request at a boundary is not acknowledged. This includes inside a handler entered by this block.
- R8: In the cycle after rti_req is sampled in idle, mem_re is 1 at address SP. In the following cycle, mem_re is 1 at SP+1, and psw_load is 1 with psw_out equal to the read data returned one cycle after the first read. In the cycle after that, pc_load is 1 with pc_out equal to the second read's data. SP then ends up 2 higher.
- R9: busy is 1 during the three return cycles and 0 after them.
- R10: If rti_req and an acceptable request arrive at the same edge, the return is taken and no acknowledge is given.
- R11: A request still held when the return restores the enable bit is acknowledged at the next boundary.
- R12: One entry followed by one return leaves the stack pointer where it started, so the next entry writes to the same two addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 1 | Level-sensitive interrupt request |
| irq_ack | output | 1 | One-cycle acknowledge to the device |
| insn_end | input | 1 | Instruction-boundary strobe from the core |
| rti_req | input | 1 | Return-from-interrupt strobe |
| busy | output | 1 | Sequence in progress; the core stalls fetch |
| pc_in | input | WORD_W | Current program counter (next instruction address) |
| psw_in | input | WORD_W | Current processor status word |
| pc_load | output | 1 | Load pc_out into the program counter |
| pc_out | output | WORD_W | New program counter value |
| psw_load | output | 1 | Load psw_out into the status word |
| psw_out | output | WORD_W | New status word value |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | STK_AW | Stack access address |
| mem_wdata | output | WORD_W | Stack write data |
| mem_rdata | input | WORD_W | Stack read data, valid one cycle after mem_re |

## Verification
The assertions assume three things about the core and memory. The core updates its PC and PSW from the load strobes, so the enable bit seen on psw_in follows what the block wrote. Read data appears exactly one cycle after a read strobe. The return strobe is only raised in idle, after an entry. The bench keeps to these rules with a small core model, which applies the load strobes, and a memory model with a registered read port. It raises rti_req only when stack contents from an earlier entry are present. It holds all inputs constant except the strobes it drives on the falling edge.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_PUSH_PC,
        ST_PUSH_PSW,
        ST_VECTOR,
        ST_POP_PSW,
        ST_POP_PC,
        ST_RESUME
    } seq_state_e;

    typedef struct packed {
        logic ack;
        logic busy;
        logic capture;
        logic push;
        logic push_psw;
        logic pop;
        logic ld_vector;
        logic ld_pop_psw;
        logic ld_pop_pc;
    } seq_ctrl_t;

endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_req,
    input  logic       insn_end,
    input  logic       rti_req,
    input  logic       ie_now,
    output seq_state_e state,
    output seq_ctrl_t  ctrl
);

    seq_state_e state_nx;
    logic       accept;

    assign accept = insn_end && irq_req && ie_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (rti_req)     state_nx = ST_POP_PSW;
                else if (accept) state_nx = ST_ACK;
            end
            ST_ACK:      state_nx = ST_PUSH_PC;
            ST_PUSH_PC:  state_nx = ST_PUSH_PSW;
            ST_PUSH_PSW: state_nx = ST_VECTOR;
            ST_VECTOR:   state_nx = ST_IDLE;
            ST_POP_PSW:  state_nx = ST_POP_PC;
            ST_POP_PC:   state_nx = ST_RESUME;
            ST_RESUME:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ctrl = '0;
        ctrl.capture = (state == ST_IDLE) && !rti_req && accept;
        unique case (state)
            ST_IDLE: ;
            ST_ACK: begin
                ctrl.ack  = 1'b1;
                ctrl.busy = 1'b1;
            end
            ST_PUSH_PC: begin
                ctrl.busy = 1'b1;
                ctrl.push = 1'b1;
            end
            ST_PUSH_PSW: begin
                ctrl.busy     = 1'b1;
                ctrl.push     = 1'b1;
                ctrl.push_psw = 1'b1;
            end
            ST_VECTOR: begin
                ctrl.busy      = 1'b1;
                ctrl.ld_vector = 1'b1;
            end
            ST_POP_PSW: begin
                ctrl.busy = 1'b1;
                ctrl.pop  = 1'b1;
            end
            ST_POP_PC: begin
                ctrl.busy       = 1'b1;
                ctrl.pop        = 1'b1;
                ctrl.ld_pop_psw = 1'b1;
            end
            ST_RESUME: begin
                ctrl.busy      = 1'b1;
                ctrl.ld_pop_pc = 1'b1;
            end
        endcase
    end

    // R2 / R3: acknowledge only follows a qualified boundary
    p_ack_after_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK) |-> $past(insn_end && irq_req && ie_now && !rti_req));

    // R3: acknowledge is one cycle wide
    p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.ack |=> !ctrl.ack);

    // R10: a return strobe in idle always starts the pop sequence
    p_rti_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rti_req) |=> (state == ST_POP_PSW));

endmodule

// File: rtl/irq_seq_stack.sv
module irq_seq_stack #(
    parameter int                 WORD_W    = 16,
    parameter int                 STK_AW    = 16,
    parameter logic [STK_AW-1:0]  STACK_TOP = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] push_data,
    output logic              mem_we,
    output logic              mem_re,
    output logic [STK_AW-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);

    localparam logic [STK_AW-1:0] STEP = STK_AW'(1);

    logic [STK_AW-1:0] sp;
    logic [STK_AW-1:0] sp_dec;
    logic [STK_AW-1:0] sp_inc;

    assign sp_dec = sp - STEP;
    assign sp_inc = sp + STEP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sp <= STACK_TOP;
        else if (push) sp <= sp_dec;
        else if (pop)  sp <= sp_inc;
    end

    always_comb begin
        mem_we    = push;
        mem_re    = pop && !push;
        mem_addr  = push ? sp_dec : sp;
        mem_wdata = push_data;
    end

    // R4: pre-decrement on push
    p_push_predec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (sp == $past(sp) - STEP));

    // R8: post-increment on pop
    p_pop_postinc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (sp == $past(sp) + STEP));

    // R4: write address is one below the pointer in use
    p_write_below_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp == $past(mem_addr)));

endmodule

// File: rtl/irq_seq_ctx.sv
module irq_seq_ctx #(
    parameter int                WORD_W       = 16,
    parameter int                IE_POS       = 15,
    parameter logic [WORD_W-1:0] HANDLER_ADDR = 16'h0040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              push_psw,
    input  logic              ld_vector,
    input  logic              ld_pop_psw,
    input  logic              ld_pop_pc,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [WORD_W-1:0] psw_in,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] push_data,
    output logic              pc_load,
    output logic [WORD_W-1:0] pc_out,
    output logic              psw_load,
    output logic [WORD_W-1:0] psw_out
);

    localparam logic [WORD_W-1:0] IE_MASK = WORD_W'(1) << IE_POS;

    logic [WORD_W-1:0] saved_pc;
    logic [WORD_W-1:0] saved_psw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saved_pc  <= '0;
            saved_psw <= '0;
        end else if (capture) begin
            saved_pc  <= pc_in;
            saved_psw <= psw_in;
        end
    end

    always_comb begin
        push_data = push_psw ? saved_psw : saved_pc;
        pc_load   = ld_vector || ld_pop_pc;
        pc_out    = ld_vector ? HANDLER_ADDR : mem_rdata;
        psw_load  = ld_vector || ld_pop_psw;
        psw_out   = ld_vector ? (saved_psw & ~IE_MASK) : mem_rdata;
    end

    // R5: the handler is entered with interrupts masked
    p_ie_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vector |-> !psw_out[IE_POS]);

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int                WORD_W       = 16,
    parameter int                STK_AW       = 16,
    parameter int                IE_POS       = 15,
    parameter logic [WORD_W-1:0] HANDLER_ADDR = 16'h0040,
    parameter logic [STK_AW-1:0] STACK_TOP    = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    output logic              irq_ack,
    input  logic              insn_end,
    input  logic              rti_req,
    output logic              busy,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [WORD_W-1:0] psw_in,
    output logic              pc_load,
    output logic [WORD_W-1:0] pc_out,
    output logic              psw_load,
    output logic [WORD_W-1:0] psw_out,
    output logic              mem_we,
    output logic              mem_re,
    output logic [STK_AW-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);

    seq_state_e        state;
    seq_ctrl_t         ctrl;
    logic [WORD_W-1:0] push_data;

    irq_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .insn_end (insn_end),
        .rti_req  (rti_req),
        .ie_now   (psw_in[IE_POS]),
        .state    (state),
        .ctrl     (ctrl)
    );

    irq_seq_ctx #(
        .WORD_W       (WORD_W),
        .IE_POS       (IE_POS),
        .HANDLER_ADDR (HANDLER_ADDR)
    ) u_ctx (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (ctrl.capture),
        .push_psw   (ctrl.push_psw),
        .ld_vector  (ctrl.ld_vector),
        .ld_pop_psw (ctrl.ld_pop_psw),
        .ld_pop_pc  (ctrl.ld_pop_pc),
        .pc_in      (pc_in),
        .psw_in     (psw_in),
        .mem_rdata  (mem_rdata),
        .push_data  (push_data),
        .pc_load    (pc_load),
        .pc_out     (pc_out),
        .psw_load   (psw_load),
        .psw_out    (psw_out)
    );

    irq_seq_stack #(
        .WORD_W    (WORD_W),
        .STK_AW    (STK_AW),
        .STACK_TOP (STACK_TOP)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ctrl.push),
        .pop       (ctrl.pop),
        .push_data (push_data),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign irq_ack = ctrl.ack;
    assign busy    = ctrl.busy;

    // R4: stack port never reads and writes together
    p_port_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R4: the acknowledge is followed by the first push
    p_push_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> mem_we);

    // R5: handler entry comes right after a stack write, at the fixed address
    p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && psw_load) |-> ($past(mem_we) && pc_out == HANDLER_ADDR));

    // R6: busy covers the acknowledge and every stack access
    p_busy_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack || mem_we || mem_re || pc_load) |-> busy);

    // R8: a restored PC follows a stack read
    p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !psw_load) |-> $past(mem_re));

endmodule

// File: tb/irq_seq_tb.sv
module irq_seq_tb;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] HANDLER    = 16'h0040;
    localparam logic [15:0] TOP        = 16'h0100;
    localparam logic [15:0] IE         = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0, insn_end = 1'b0, rti_req = 1'b0;
    logic        irq_ack, busy, pc_load, psw_load, mem_we, mem_re;
    logic [15:0] pc_out, psw_out, mem_addr, mem_wdata;
    logic [15:0] mem_rdata;
    logic [15:0] cpu_pc, cpu_psw;
    logic        set_en = 1'b0;
    logic [15:0] set_pc = '0, set_psw = '0;
    logic [15:0] mem [256];

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [15:0] exp_sp;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_seq u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
        .insn_end(insn_end), .rti_req(rti_req), .busy(busy),
        .pc_in(cpu_pc), .psw_in(cpu_psw), .pc_load(pc_load), .pc_out(pc_out),
        .psw_load(psw_load), .psw_out(psw_out), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // core register model and stack memory model
    always @(posedge clk) begin
        if (pc_load)     cpu_pc <= pc_out;
        else if (set_en) cpu_pc <= set_pc;
        if (psw_load)    cpu_psw <= psw_out;
        else if (set_en) cpu_psw <= set_psw;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            report();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_cpu(input logic [15:0] pc, input logic [15:0] psw);
        @(negedge clk);
        set_en = 1'b1; set_pc = pc; set_psw = psw;
        @(negedge clk);
        set_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ack", irq_ack, 0);
        chk("R1 busy", busy, 0);
        chk("R1 mem", {mem_we, mem_re}, 0);
        chk("R1 loads", {pc_load, psw_load}, 0);
    endtask

    task automatic t_no_boundary();
        @(negedge clk); irq_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R2 no ack off boundary", irq_ack, 0);
        end
        irq_req = 1'b0;
        @(negedge clk); insn_end = 1'b1;
        @(negedge clk); insn_end = 1'b0;
        chk("R2 dropped request", irq_ack, 0);
        chk("R2 no stack write", mem_we, 0);
    endtask

    task automatic t_masked();
        set_cpu(16'h2222, 16'h0003);
        @(negedge clk); irq_req = 1'b1; insn_end = 1'b1;
        @(negedge clk); insn_end = 1'b0; irq_req = 1'b0;
        chk("R7 masked ack", irq_ack, 0);
        chk("R7 masked busy", busy, 0);
        @(negedge clk);
        chk("R7 masked write", mem_we, 0);
    endtask

    task automatic t_entry(input logic [15:0] pc, input logic [15:0] psw, input bit keep_irq);
        set_cpu(pc, psw);
        @(negedge clk); irq_req = 1'b1; insn_end = 1'b1;
        @(negedge clk); insn_end = 1'b0; irq_req = keep_irq;
        chk("R3 ack high", irq_ack, 1);
        chk("R6 busy at ack", busy, 1);
        chk("R4 no write at ack", mem_we, 0);
        @(negedge clk);
        chk("R3 ack one cycle", irq_ack, 0);
        chk("R4 pc push we", mem_we, 1);
        chk("R4 pc push addr", mem_addr, exp_sp - 16'd1);
        chk("R4 pc push data", mem_wdata, pc);
        @(negedge clk);
        chk("R4 psw push addr", mem_addr, exp_sp - 16'd2);
        chk("R4 psw push data", mem_wdata, psw);
        chk("R4 no read", mem_re, 0);
        @(negedge clk);
        chk("R5 loads", {pc_load, psw_load}, 2'b11);
        chk("R5 handler addr", pc_out, HANDLER);
        chk("R5 psw ie cleared", psw_out, psw & ~IE);
        chk("R6 busy at vector", busy, 1);
        @(negedge clk);
        chk("R6 busy drops", busy, 0);
        chk("R5 core pc", cpu_pc, HANDLER);
        exp_sp = exp_sp - 16'd2;
    endtask

    task automatic t_return(input logic [15:0] pc, input logic [15:0] psw, input bit with_irq);
        @(negedge clk); rti_req = 1'b1;
        if (with_irq) begin irq_req = 1'b1; insn_end = 1'b1; end
        @(negedge clk); rti_req = 1'b0; insn_end = 1'b0;
        if (with_irq) begin
            irq_req = 1'b0;
            chk("R10 no ack on return", irq_ack, 0);
        end
        chk("R8 first read", mem_re, 1);
        chk("R8 first addr", mem_addr, exp_sp);
        chk("R9 busy pop", busy, 1);
        @(negedge clk);
        chk("R8 second addr", mem_addr, exp_sp + 16'd1);
        chk("R8 psw load", psw_load, 1);
        chk("R8 psw value", psw_out, psw);
        @(negedge clk);
        chk("R8 pc load", pc_load, 1);
        chk("R8 pc value", pc_out, pc);
        chk("R9 busy resume", busy, 1);
        @(negedge clk);
        chk("R9 busy drops", busy, 0);
        chk("R8 core pc", cpu_pc, pc);
        chk("R8 core psw", cpu_psw, psw);
        exp_sp = exp_sp + 16'd2;
    endtask

    task automatic t_held_request();
        // inside handler the enable is clear: held request waits (R7)
        @(negedge clk); insn_end = 1'b1;
        @(negedge clk); insn_end = 1'b0;
        chk("R7 handler masked", irq_ack, 0);
        t_return(16'h3456, 16'h8011, 1'b0);
        @(negedge clk); insn_end = 1'b1;
        @(negedge clk); insn_end = 1'b0; irq_req = 1'b0;
        chk("R11 re-serviced", irq_ack, 1);
        @(negedge clk);
        chk("R12 same pc addr", mem_addr, TOP - 16'd1);
        repeat (3) @(negedge clk);
        exp_sp = exp_sp - 16'd2;
    endtask

    initial begin
        cpu_pc = 16'h1000; cpu_psw = IE;
        mem_rdata = '0;
        exp_sp = TOP;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_boundary();
        t_masked();
        t_entry(16'h1234, 16'h8005, 1'b0);
        t_return(16'h1234, 16'h8005, 1'b0);
        chk("R12 sp balanced", exp_sp, TOP);
        t_entry(16'h3456, 16'h8011, 1'b1);
        t_held_request();
        // R10: handler sets enable again, then return and request collide
        set_cpu(HANDLER, IE);
        t_return(16'h3456, 16'h8011, 1'b1);
        repeat (2) @(negedge clk);
        chk("R10 stays idle", busy, 0);
        report();
    end

endmodule